// File: doc/BRIEF.md
# SPI Master Transmitter with Held Data Line

This block is an SPI master that sends one 8-bit byte per frame in clock mode 0 (SCLK idles low, data changes on the falling edge and is sampled on the rising edge). The most significant bit goes out first. A byte is offered on a valid/ready handshake. A divider input sets the SCLK rate, and the block drives SCLK, MOSI and an active-low slave select. Busy and done outputs report the state of the transfer.

The block does not return MOSI to a fixed idle level between frames. A one-bit hold register takes the last bit of the byte in the same cycle that bit appears on MOSI. When slave select is high, an output multiplexer drives MOSI from this hold register. The multiplexer therefore switches between two equal values, and MOSI does not move at the end of the frame. This removes the half-period low pulse that a trailing 1 can show in a simpler design.

Top module: `spi_hold_tx`

## Requirements
- R1: After reset, ss_n is 1, sclk is 0, mosi is 0, tx_ready is 1, busy is 0 and done is 0.
- R2: A byte is accepted only on a clock edge where tx_valid and tx_ready are both 1. A tx_valid pulse while tx_ready is 0 has no effect: it starts no frame and does not change the byte being sent.
- R3: A frame carries the 8 bits of the accepted byte, bit 7 first. MOSI changes only on the system clock edge where sclk falls, so each bit is stable across its rising sclk edge.
- R4: Each sclk half period lasts div+1 system clocks, where div is the value present on the accept edge. A frame has exactly 8 sclk pulses.
- R5: ss_n goes low in the cycle after the accept edge and stays low for 16*(div+1) system clocks. sclk is high only while ss_n is low.
- R6: While ss_n is high after a frame, mosi equals bit 0 of the last byte sent and does not change until the next frame begins.
- R7: From the falling sclk edge that presents bit 0 through the cycles after ss_n rises, mosi holds a constant value.
- R8: done is high for exactly one system clock, in the first cycle that ss_n is high after a frame.
- R9: After ss_n rises, tx_ready stays 0 for 2*(div+1) system clocks and then returns to 1.
- R10: busy is the inverse of tx_ready. It is 1 from the cycle after the accept edge until tx_ready returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | DIV_W | SCLK half period, minus one, in system clocks |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Block can accept a byte |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | A frame or its trailing gap is in progress |
| done | output | 1 | One-cycle pulse when a frame ends |

## Verification
The hardest case to reach is the end of a frame whose last bit is 1. This is where a simpler design drops MOSI for half a period before slave select rises. The bench sends bytes ending in 1 and bytes ending in 0, at several divider values. It checks every system clock from the presentation of bit 0 through the rise of ss_n and into the idle gap. A second hard case is a valid offered while the block is busy. The bench raises tx_valid with a different byte in the middle of a frame, drops it before the gap ends, and then confirms that the frame bits, the held level and the idle line show no trace of that byte.

// File: rtl/spi_hold_tx.sv
module spi_hold_tx #(
  parameter int DIV_W      = 8,
  parameter int FRAME_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             sclk,
  output logic             mosi,
  output logic             ss_n,
  output logic             busy,
  output logic             done
);
  localparam int HALF_W    = $clog2(2*FRAME_BITS);
  localparam int LAST_HALF = 2*FRAME_BITS-1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  st_t                   st;
  logic [DIV_W-1:0]      cnt, div_q;
  logic [HALF_W-1:0]     half;
  logic [FRAME_BITS-1:0] sreg;
  logic                  hold;

  assign tx_ready = (st == S_IDLE);
  assign busy     = !tx_ready;
  assign ss_n     = (st != S_XFER);
  assign sclk     = !ss_n && half[0];
  assign mosi     = ss_n ? hold : sreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      div_q <= '0;
      half  <= '0;
      sreg  <= '0;
      hold  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (tx_valid) begin
          st    <= S_XFER;
          sreg  <= FRAME_BITS'(tx_data);
          div_q <= div;
          cnt   <= div;
          half  <= '0;
        end
        S_XFER: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          cnt <= div_q;
          if (half == HALF_W'(LAST_HALF)) begin
            st   <= S_GAP;
            half <= '0;
            done <= 1'b1;
          end else begin
            half <= half + 1'b1;
            if (half[0]) begin
              sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
              if (half == HALF_W'(LAST_HALF-2)) hold <= sreg[FRAME_BITS-2];
            end
          end
        end
        S_GAP: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          cnt <= div_q;
          if (half == HALF_W'(1)) st <= S_IDLE;
          else half <= half + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_hold_tx_chk.sv
module spi_hold_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_ready,
  input logic sclk,
  input logic mosi,
  input logic ss_n,
  input logic busy,
  input logic done
);
  assert_done_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ss_n && !$past(ss_n)));
  assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n)) |-> $stable(mosi));
  assert_no_glitch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> (mosi == $past(mosi)));
  assert_mode0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && $past(!ss_n) && !$stable(mosi)) |-> $fell(sclk));
  assert_sclk_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !ss_n);
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (ss_n && !sclk && !busy));
endmodule

bind spi_hold_tx spi_hold_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .sclk(sclk),
  .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done)
);

// File: tb/tb_spi_hold_tx.sv
`timescale 1ns/1ps
module tb_spi_hold_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = '0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, sclk, mosi, ss_n, busy, done;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  spi_hold_tx dut (
    .clk(clk), .rst_n(rst_n), .div(div), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    check("R1 ss_n", ss_n, 1);
    check("R1 sclk", sclk, 0);
    check("R1 mosi", mosi, 0);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
  endtask

  // Sends one byte and checks the full frame; spam offers a different byte mid-frame.
  task automatic send_frame(input logic [7:0] b, input int d, input bit spam);
    int lows = 0, pulses = 0, highs = 0, glitches = 0, mode_bad = 0;
    int after_last = 0;
    logic [7:0] got = '0;
    logic prev_sclk = 1'b0, prev_mosi;
    int seen = 0;
    while (!tx_ready) @(negedge clk);
    div = 8'(d);
    tx_data = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data = ~b;
    check("R5 ss_n low after accept", ss_n, 0);
    check("R10 busy after accept", busy, 1);
    prev_mosi = mosi;
    while (!ss_n) begin
      lows++;
      if (spam) begin
        if (lows == 3) begin tx_data = 8'h3C ^ b; tx_valid = 1'b1; end
        if (lows == 9) tx_valid = 1'b0;
        if (tx_ready) mode_bad++;
      end
      if (!prev_sclk && sclk) begin
        got = {got[6:0], mosi};
        pulses++;
      end
      if (lows > 1 && mosi != prev_mosi && !(prev_sclk && !sclk)) mode_bad++;
      if (pulses == 8 && !sclk) after_last = 1;
      if (pulses == 7 && prev_sclk && !sclk) after_last = 1;
      if (after_last && mosi != b[0]) glitches++;
      prev_sclk = sclk;
      prev_mosi = mosi;
      @(negedge clk);
      seen++;
      if (seen > 5000) break;
    end
    check("R3 byte shifted msb first", got, b);
    check("R3 mosi changes only at sclk fall", mode_bad, 0);
    check("R4 sclk pulse count", pulses, 8);
    check("R5 ss_n low duration", lows, 16*(d+1));
    check("R8 done with ss_n rise", done, 1);
    check("R7 mosi across ss_n rise", mosi, prev_mosi);
    check("R7 no glitch in last bit", glitches, 0);
    while (!tx_ready) begin
      highs++;
      if (mosi != b[0]) glitches++;
      if (highs > 1 && done) glitches++;
      if (!busy || sclk) glitches++;
      @(negedge clk);
      if (highs > 5000) break;
    end
    check("R9 gap before ready", highs, 2*(d+1));
    check("R6 held level in gap, R8 single done, R10 busy", glitches, 0);
    repeat (6) begin
      check("R6 held level when idle", mosi, b[0]);
      @(negedge clk);
    end
    if (spam) check("R2 ignored offer starts no frame", ss_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    send_frame(8'hA5, 0, 1'b0);
    send_frame(8'h01, 1, 1'b0);
    send_frame(8'hFE, 2, 1'b0);
    send_frame(8'h80, 0, 1'b0);
    send_frame(8'hFF, 3, 1'b0);
    send_frame(8'hFF, 0, 1'b0);
    send_frame(8'h00, 1, 1'b0);
    send_frame(8'h6B, 1, 1'b1);
    send_frame(8'h52, 2, 1'b1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule